// File: doc/BRIEF.md
# Direct-Mode Data Address Generator

This block produces the 16-bit data-memory address for direct-addressed operands and for stack pushes and pops in a small DSP-style core. An instruction supplies only a 7-bit offset. The block combines that offset with a base that depends on the mode. In page-relative mode the base is a 9-bit page pointer. In stack-relative mode the base is the 16-bit stack pointer. In memory-mapped-register mode the base is zero, so the address always falls in 0000h–007Fh.

The block holds the page pointer and the stack pointer itself. Both can be loaded from the core. The stack grows downward, and the stack pointer always names the most recently pushed word. One address is issued per cycle. When several requests arrive in the same cycle, a fixed priority picks one. The address and its valid flag are registered.

Top module: `dirAddrGen`

## Requirements
- R1: With a direct request, `cplMode`=0 and `mmrMode`=0, the address is the page pointer in bits 15..7 and the offset in bits 6..0.
- R2: With a direct request, `cplMode`=1 and `mmrMode`=0, the address is the stack pointer plus the zero-extended offset, modulo 2^16.
- R3: With a direct request and `mmrMode`=1, bits 15..7 of the address are zero and bits 6..0 are the offset. This holds whatever the value of `cplMode`, the page pointer or the stack pointer.
- R4: A request with `mmrMode`=1 wins over everything else in its cycle. Any push, pop or pointer load in that cycle is ignored, and both pointers keep their values.
- R5: A push first decrements the stack pointer by one and then issues the new value as the address. The pointer wraps from 0000h to FFFFh.
- R6: A pop issues the current stack pointer as the address and then increments the pointer by one. The pointer wraps from FFFFh to 0000h.
- R7: When push and pop arrive together, the push is served and the pop is ignored. When a push or pop arrives with a direct request that is not an MMR request, the stack operation is served and the direct request is dropped.
- R8: `effAddr` and `addrValid` change one clock edge after the request is sampled. In a cycle with no accepted request, `addrValid` is 0 and `effAddr` keeps its last value.
- R9: A synchronous reset clears the stack pointer, the page pointer, `effAddr` and `addrValid` to zero.
- R10: A page load takes effect at the next edge. A direct request in the same cycle as a page load still uses the old page. A stack-pointer load is ignored when a push or pop is accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Direct-address request |
| cplMode | input | 1 | Base select: 0 = page pointer, 1 = stack pointer |
| mmrMode | input | 1 | Memory-mapped-register access; forces the upper address bits to zero |
| dirOffset | input | 7 | Offset taken from the instruction |
| pushReq | input | 1 | Push strobe |
| popReq | input | 1 | Pop strobe |
| dpLoadEn | input | 1 | Load the page pointer |
| dpLoadVal | input | 9 | Value for a page-pointer load |
| spLoadEn | input | 1 | Load the stack pointer |
| spLoadVal | input | 16 | Value for a stack-pointer load |
| addrValid | output | 1 | `effAddr` was updated at the last edge |
| effAddr | output | 16 | Registered effective address |
| dpOut | output | 9 | Current page pointer |
| spOut | output | 16 | Current stack pointer |

## Verification
The hard cases are the cycles where several functions meet. A push can arrive together with a pop. A stack operation can arrive together with a direct request or a stack-pointer load. An MMR request can arrive together with a push and both pointer loads. The bench drives these combinations on purpose in single cycles. After each one it checks, at the ports, which address was issued and where both pointers ended up, so a dropped request or a leaked pointer update is visible.

// File: rtl/dag_pkg.sv
package dag_pkg;

  // Strobes from the control decode to the datapath, one accepted operation per cycle
  typedef struct packed {
    logic takeMmr;     // MMR direct access, zero base
    logic takePush;    // pre-decrement and issue
    logic takePop;     // issue and post-increment
    logic takeDirect;  // page- or stack-relative direct access
    logic stackBase;   // base select for takeDirect
    logic ldDp;        // page pointer load accepted
    logic ldSp;        // stack pointer load accepted
    logic anyTake;     // an address is issued this cycle
  } ctrlStrobeT;

endpackage

// File: rtl/dagCtrl.sv
module dagCtrl
  import dag_pkg::*;
(
  input  logic       reqValid,
  input  logic       cplMode,
  input  logic       mmrMode,
  input  logic       pushReq,
  input  logic       popReq,
  input  logic       dpLoadEn,
  input  logic       spLoadEn,
  output ctrlStrobeT strb
);

  logic mmrHit;
  logic stackOp;

  always_comb begin
    mmrHit  = reqValid & mmrMode;
    stackOp = (pushReq | popReq) & ~mmrHit;

    strb.takeMmr    = mmrHit;
    strb.takePush   = pushReq & ~mmrHit;
    strb.takePop    = popReq & ~pushReq & ~mmrHit;
    strb.takeDirect = reqValid & ~mmrMode & ~pushReq & ~popReq;
    strb.stackBase  = cplMode;
    strb.ldDp       = dpLoadEn & ~mmrHit;
    strb.ldSp       = spLoadEn & ~mmrHit & ~stackOp;
    strb.anyTake    = mmrHit | stackOp | strb.takeDirect;
  end

endmodule

// File: rtl/dagDatapath.sv
module dagDatapath
  import dag_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 7
) (
  input  logic                      clk,
  input  logic                      rst,
  input  ctrlStrobeT                strb,
  input  logic [OFS_W-1:0]          dirOffset,
  input  logic [ADDR_W-OFS_W-1:0]   dpLoadVal,
  input  logic [ADDR_W-1:0]         spLoadVal,
  output logic                      addrValid,
  output logic [ADDR_W-1:0]         effAddr,
  output logic [ADDR_W-OFS_W-1:0]   dpOut,
  output logic [ADDR_W-1:0]         spOut
);

  localparam int PAGE_W = ADDR_W - OFS_W;
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [PAGE_W-1:0] dpQ;
  logic [ADDR_W-1:0] spQ;
  logic [ADDR_W-1:0] spDec;
  logic [ADDR_W-1:0] spInc;
  logic [ADDR_W-1:0] ofsExt;
  logic [ADDR_W-1:0] pageAddr;
  logic [ADDR_W-1:0] stackAddr;
  logic [ADDR_W-1:0] nextAddr;
  logic [ADDR_W-1:0] validAddrQ;
  logic              validQ;

  always_comb begin
    ofsExt    = {{PAGE_W{1'b0}}, dirOffset};
    spDec     = spQ - ONE;
    spInc     = spQ + ONE;
    pageAddr  = {dpQ, dirOffset};
    stackAddr = spQ + ofsExt;
    if (strb.takeMmr)         nextAddr = ofsExt;
    else if (strb.takePush)   nextAddr = spDec;
    else if (strb.takePop)    nextAddr = spQ;
    else if (strb.stackBase)  nextAddr = stackAddr;
    else                      nextAddr = pageAddr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      spQ        <= '0;
      dpQ        <= '0;
      validQ     <= 1'b0;
      validAddrQ <= '0;
    end else begin
      if (strb.takePush)      spQ <= spDec;
      else if (strb.takePop)  spQ <= spInc;
      else if (strb.ldSp)     spQ <= spLoadVal;
      if (strb.ldDp)          dpQ <= dpLoadVal;
      validQ <= strb.anyTake;
      if (strb.anyTake)       validAddrQ <= nextAddr;
    end
  end

  assign addrValid = validQ;
  assign effAddr   = validAddrQ;
  assign dpOut     = dpQ;
  assign spOut     = spQ;

endmodule

// File: rtl/dirAddrGen.sv
module dirAddrGen
  import dag_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 7
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    reqValid,
  input  logic                    cplMode,
  input  logic                    mmrMode,
  input  logic [OFS_W-1:0]        dirOffset,
  input  logic                    pushReq,
  input  logic                    popReq,
  input  logic                    dpLoadEn,
  input  logic [ADDR_W-OFS_W-1:0] dpLoadVal,
  input  logic                    spLoadEn,
  input  logic [ADDR_W-1:0]       spLoadVal,
  output logic                    addrValid,
  output logic [ADDR_W-1:0]       effAddr,
  output logic [ADDR_W-OFS_W-1:0] dpOut,
  output logic [ADDR_W-1:0]       spOut
);

  ctrlStrobeT strb;

  dagCtrl ctrl_i (
    .reqValid (reqValid),
    .cplMode  (cplMode),
    .mmrMode  (mmrMode),
    .pushReq  (pushReq),
    .popReq   (popReq),
    .dpLoadEn (dpLoadEn),
    .spLoadEn (spLoadEn),
    .strb     (strb)
  );

  dagDatapath #(
    .ADDR_W (ADDR_W),
    .OFS_W  (OFS_W)
  ) dp_i (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .dirOffset (dirOffset),
    .dpLoadVal (dpLoadVal),
    .spLoadVal (spLoadVal),
    .addrValid (addrValid),
    .effAddr   (effAddr),
    .dpOut     (dpOut),
    .spOut     (spOut)
  );

endmodule

// File: rtl/dirAddrGen_chk.sv
module dirAddrGen_chk #(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 7
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    reqValid,
  input logic                    cplMode,
  input logic                    mmrMode,
  input logic [OFS_W-1:0]        dirOffset,
  input logic                    pushReq,
  input logic                    popReq,
  input logic                    addrValid,
  input logic [ADDR_W-1:0]       effAddr,
  input logic [ADDR_W-OFS_W-1:0] dpOut,
  input logic [ADDR_W-1:0]       spOut
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic rstSeen = 1'b0;
  logic pastOk  = 1'b0;
  logic prevRst = 1'b0;

  always_ff @(posedge clk) begin
    rstSeen <= rstSeen | rst;
    pastOk  <= (rstSeen | rst) & ~rst;
    prevRst <= rst;
  end

  // R9
  p_reset_clear_r9: assert property (@(posedge clk)
    prevRst |-> (spOut == '0 && dpOut == '0 && !addrValid && effAddr == '0));

  // R1
  p_page_addr_r1: assert property (@(posedge clk) disable iff (rst)
    (pastOk && $past(reqValid && !mmrMode && !cplMode && !pushReq && !popReq))
    |-> (addrValid && effAddr == {$past(dpOut), $past(dirOffset)}));

  // R3
  p_mmr_upper_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (pastOk && $past(reqValid && mmrMode))
    |-> (addrValid && effAddr[ADDR_W-1:OFS_W] == '0 && effAddr[OFS_W-1:0] == $past(dirOffset)));

  // R4
  p_mmr_keeps_ptrs_r4: assert property (@(posedge clk) disable iff (rst)
    (pastOk && $past(reqValid && mmrMode))
    |-> (spOut == $past(spOut) && dpOut == $past(dpOut)));

  // R5
  p_push_dec_r5: assert property (@(posedge clk) disable iff (rst)
    (pastOk && $past(pushReq && !(reqValid && mmrMode)))
    |-> (spOut == $past(spOut) - ONE && effAddr == spOut && addrValid));

  // R6 and R7: pop served only without push
  p_pop_inc_r6: assert property (@(posedge clk) disable iff (rst)
    (pastOk && $past(popReq && !pushReq && !(reqValid && mmrMode)))
    |-> (spOut == $past(spOut) + ONE && effAddr == $past(spOut) && addrValid));

  // R8
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (pastOk && $past(!reqValid && !pushReq && !popReq))
    |-> (!addrValid && $stable(effAddr)));

endmodule

bind dirAddrGen dirAddrGen_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .reqValid  (reqValid),
  .cplMode   (cplMode),
  .mmrMode   (mmrMode),
  .dirOffset (dirOffset),
  .pushReq   (pushReq),
  .popReq    (popReq),
  .addrValid (addrValid),
  .effAddr   (effAddr),
  .dpOut     (dpOut),
  .spOut     (spOut)
);

// File: tb/dirAddrGen_tb_top.sv
module dirAddrGen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 17;

  typedef struct packed {
    logic        req;
    logic        cpl;
    logic        mmr;
    logic [6:0]  ofs;
    logic        push;
    logic        pop;
    logic        dpLd;
    logic [8:0]  dpVal;
    logic        spLd;
    logic [15:0] spVal;
    logic        expV;
    logic [15:0] expA;
    logic [15:0] expSp;
    logic [8:0]  expDp;
  } vecT;

  localparam vecT TBL [NV] = '{
    '{1'b0,1'b0,1'b0,7'h00,1'b0,1'b0,1'b1,9'h1A3,1'b0,16'h0000, 1'b0,16'h0000,16'h0000,9'h1A3},
    '{1'b0,1'b0,1'b0,7'h00,1'b0,1'b0,1'b0,9'h000,1'b1,16'h8000, 1'b0,16'h0000,16'h8000,9'h1A3},
    '{1'b1,1'b0,1'b0,7'h55,1'b0,1'b0,1'b0,9'h000,1'b0,16'h0000, 1'b1,16'hD1D5,16'h8000,9'h1A3},
    '{1'b1,1'b1,1'b0,7'h10,1'b0,1'b0,1'b0,9'h000,1'b0,16'h0000, 1'b1,16'h8010,16'h8000,9'h1A3},
    '{1'b1,1'b1,1'b1,7'h7F,1'b0,1'b0,1'b0,9'h000,1'b0,16'h0000, 1'b1,16'h007F,16'h8000,9'h1A3},
    '{1'b0,1'b0,1'b0,7'h00,1'b1,1'b0,1'b0,9'h000,1'b0,16'h0000, 1'b1,16'h7FFF,16'h7FFF,9'h1A3},
    '{1'b0,1'b0,1'b0,7'h00,1'b1,1'b0,1'b0,9'h000,1'b0,16'h0000, 1'b1,16'h7FFE,16'h7FFE,9'h1A3},
    '{1'b0,1'b0,1'b0,7'h00,1'b0,1'b1,1'b0,9'h000,1'b0,16'h0000, 1'b1,16'h7FFE,16'h7FFF,9'h1A3},
    '{1'b0,1'b0,1'b0,7'h00,1'b1,1'b1,1'b0,9'h000,1'b0,16'h0000, 1'b1,16'h7FFE,16'h7FFE,9'h1A3},
    '{1'b1,1'b0,1'b0,7'h01,1'b0,1'b1,1'b0,9'h000,1'b0,16'h0000, 1'b1,16'h7FFE,16'h7FFF,9'h1A3},
    '{1'b1,1'b0,1'b1,7'h25,1'b1,1'b0,1'b1,9'h055,1'b1,16'h1234, 1'b1,16'h0025,16'h7FFF,9'h1A3},
    '{1'b0,1'b0,1'b0,7'h00,1'b0,1'b0,1'b0,9'h000,1'b0,16'h0000, 1'b0,16'h0025,16'h7FFF,9'h1A3},
    '{1'b0,1'b0,1'b0,7'h00,1'b0,1'b1,1'b0,9'h000,1'b1,16'hFFFF, 1'b1,16'h7FFF,16'h8000,9'h1A3},
    '{1'b0,1'b0,1'b0,7'h00,1'b0,1'b0,1'b0,9'h000,1'b1,16'hFFF0, 1'b0,16'h7FFF,16'hFFF0,9'h1A3},
    '{1'b1,1'b1,1'b0,7'h7F,1'b0,1'b0,1'b0,9'h000,1'b0,16'h0000, 1'b1,16'h006F,16'hFFF0,9'h1A3},
    '{1'b1,1'b0,1'b0,7'h02,1'b0,1'b0,1'b1,9'h0FF,1'b0,16'h0000, 1'b1,16'hD182,16'hFFF0,9'h0FF},
    '{1'b1,1'b0,1'b0,7'h03,1'b0,1'b0,1'b0,9'h000,1'b0,16'h0000, 1'b1,16'h7F83,16'hFFF0,9'h0FF}
  };

  localparam string TAGS [NV] = '{
    "R10", "R10", "R1", "R2", "R3", "R5", "R5", "R6", "R7",
    "R7", "R4", "R8", "R10", "R10", "R2", "R10", "R1"
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        reqValid, cplMode, mmrMode, pushReq, popReq, dpLoadEn, spLoadEn;
  logic [6:0]  dirOffset;
  logic [8:0]  dpLoadVal;
  logic [15:0] spLoadVal;
  logic        addrValid;
  logic [15:0] effAddr;
  logic [8:0]  dpOut;
  logic [15:0] spOut;

  int totalCnt = 0;
  int failCnt  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dirAddrGen dut_i (
    .clk(clk), .rst(rst), .reqValid(reqValid), .cplMode(cplMode), .mmrMode(mmrMode),
    .dirOffset(dirOffset), .pushReq(pushReq), .popReq(popReq), .dpLoadEn(dpLoadEn),
    .dpLoadVal(dpLoadVal), .spLoadEn(spLoadEn), .spLoadVal(spLoadVal),
    .addrValid(addrValid), .effAddr(effAddr), .dpOut(dpOut), .spOut(spOut)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    totalCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vecT v);
    reqValid = v.req;  cplMode = v.cpl;  mmrMode = v.mmr;  dirOffset = v.ofs;
    pushReq = v.push;  popReq = v.pop;
    dpLoadEn = v.dpLd; dpLoadVal = v.dpVal;
    spLoadEn = v.spLd; spLoadVal = v.spVal;
  endtask

  // one cycle: drive at negedge, sample just after the following rising edge
  task automatic step(input vecT v, input string tag);
    @(negedge clk);
    drive(v);
    @(posedge clk);
    #1;
    check(tag, {23'd0, addrValid, effAddr, spOut, dpOut},
               {23'd0, v.expV, v.expA, v.expSp, v.expDp});
  endtask

  function automatic vecT mk(input logic req, input logic cpl, input logic mmr,
                             input logic [6:0] ofs, input logic push, input logic pop,
                             input logic spLd, input logic [15:0] spVal,
                             input logic expV, input logic [15:0] expA,
                             input logic [15:0] expSp, input logic [8:0] expDp);
    vecT v;
    v = '{req, cpl, mmr, ofs, push, pop, 1'b0, 9'h000, spLd, spVal, expV, expA, expSp, expDp};
    return v;
  endfunction

  initial begin
    #(CLK_PERIOD * 5000);
    failCnt++;
    totalCnt++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

  initial begin
    rst = 1'b1;
    drive('0);
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset state", {23'd0, addrValid, effAddr, spOut, dpOut}, 64'd0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) step(TBL[i], TAGS[i]);

    // R8: one-clock latency, nothing visible before the edge
    step(mk(0,0,0,7'h00,0,0,0,16'h0000, 0,16'h7F83,16'hFFF0,9'h0FF), "R8 idle hold");
    @(negedge clk);
    drive(mk(1,0,1,7'h11,0,0,0,16'h0000, 0,0,0,0));
    #1;
    check("R8 not before edge", {63'd0, addrValid}, 64'd0);
    @(posedge clk);
    #1;
    check("R8 after edge", {47'd0, addrValid, effAddr}, {47'd0, 1'b1, 16'h0011});

    // R5 and R6 wrap at the ends of the address space
    step(mk(0,0,0,7'h00,0,0,1,16'h0000, 0,16'h0011,16'h0000,9'h0FF), "R10 sp load zero");
    step(mk(0,0,0,7'h00,1,0,0,16'h0000, 1,16'hFFFF,16'hFFFF,9'h0FF), "R5 push wrap");
    step(mk(0,0,0,7'h00,0,1,0,16'h0000, 1,16'hFFFF,16'h0000,9'h0FF), "R6 pop wrap");

    // R3 with page base selected and a nonzero page
    step(mk(1,0,1,7'h40,0,0,0,16'h0000, 1,16'h0040,16'h0000,9'h0FF), "R3 mmr page mode");

    // R9: reset in mid-run
    @(negedge clk);
    drive('0);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R9 mid-run reset", {23'd0, addrValid, effAddr, spOut, dpOut}, 64'd0);
    @(negedge clk);
    rst = 1'b0;

    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

endmodule